// File: doc/BRIEF.md
# Accumulator Bit-Field Extract Unit

This block pulls a right-justified bit field out of one of four 64-bit accumulators and then moves a position pointer down past the bits it consumed. Each accumulator is a pair of 32-bit halves: the high word forms bits 63..32 and the low word forms bits 31..0. The pointer lives in the low six bits of a 32-bit control register. Bit 14 of that register is a flag that reports whether the last extraction failed.

A request carries a 2-bit accumulator selector, a 5-bit size operand and a strobe. The field returned is size+1 bits wide and ends at the current pointer. One cycle after the strobe, a done pulse comes with the zero-extended result. On the same edge the pointer and the flag are rewritten. Every other control bit keeps its previous value.

The control register can be loaded whole and read back. Accumulator pairs are loaded through a separate write port.

Top module: `acc_extract_unit`

## Requirements
- R1: A write strobe on the accumulator port loads the selected pair's high and low words. An extraction from that pair sees the 64-bit value {high, low}. An extraction in the same cycle as a write reads the value from before the write.
- R2: The result holds accumulator bits [pos : pos-size]. These bits are right-justified and zero-extended to 32 bits, where pos is control bits [5:0] and size is the request operand (0..31).
- R3: An extraction succeeds when pos >= size. On success, control bits [5:0] become (pos-size-1) modulo 64 and control bit 14 is cleared.
- R4: An extraction fails when pos < size. On failure, control bit 14 is set, control bits [5:0] keep their value and the result is zero.
- R5: An extraction changes only control bits [5:0] and bit 14. Bits [31:15] and [13:6] keep their previous contents.
- R6: Take pos 0 and size 0 with all other control bits at zero. The result is accumulator bit 0 and the control register reads 0x0000003F afterwards.
- R7: The done output is high exactly in the cycle after each request strobe and low otherwise. The result output holds its last value until the next request.
- R8: A control write loads all 32 bits, which then appear on the read port from the next cycle. When a control write and a request coincide, the written value wins over the extraction update.
- R9: With pos 63 and size 31, the result is the full high word of the accumulator and the pointer becomes 31.
- R10: After reset, the control register, all accumulator words, the result and done are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accWrEn | input | 1 | Accumulator pair write strobe |
| accWrSel | input | 2 | Accumulator pair to write |
| accWrHi | input | 32 | High word to write |
| accWrLo | input | 32 | Low word to write |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 32 | Control register write value |
| ctlRdData | output | 32 | Current control register contents |
| reqValid | input | 1 | Extraction request strobe |
| reqAcc | input | 2 | Accumulator pair to extract from |
| reqSize | input | 5 | Field size minus one |
| resValid | output | 1 | Done pulse, one cycle after the request |
| resData | output | 32 | Extracted field, zero-extended |

## Verification
The hardest state to reach is the boundary where an extraction uses up the pointer exactly and it wraps to 63. A close second is the failure that follows one request later. To reach both, the bench loads a pointer with many unrelated control bits set. It then issues a chain of same-size requests from that pointer until the pointer passes zero. It also forces the pos 0, size 0 case from an all-zero register and the pos 63, size 31 full-word case. Randomised requests mixed with concurrent control and accumulator writes then check the priority rules against the bench's own model on every clock.

// File: rtl/aeu_pkg.sv
package aeu_pkg;
  typedef struct packed {
    logic loadCtl;       // whole control register from the write port
    logic applyExtract;  // pointer/flag update from an extraction
    logic captureResult; // latch the extracted field
  } aeuStrobes_t;
endpackage

// File: rtl/aeu_control.sv
module aeu_control
  import aeu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        ctlWrEn,
  output aeuStrobes_t strobes,
  output logic        resValid
);
  always_comb begin
    strobes.loadCtl       = ctlWrEn;
    strobes.applyExtract  = reqValid & ~ctlWrEn;
    strobes.captureResult = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end
endmodule

// File: rtl/aeu_datapath.sv
module aeu_datapath
  import aeu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_ACC = 4,
  parameter int SIZE_W  = 5,
  parameter int FLAG_BIT = 14
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  aeuStrobes_t                strobes,
  input  logic                       accWrEn,
  input  logic [$clog2(NUM_ACC)-1:0] accWrSel,
  input  logic [DATA_W-1:0]          accWrHi,
  input  logic [DATA_W-1:0]          accWrLo,
  input  logic [DATA_W-1:0]          ctlWrData,
  input  logic [$clog2(NUM_ACC)-1:0] reqAcc,
  input  logic [SIZE_W-1:0]          reqSize,
  output logic [DATA_W-1:0]          ctlReg,
  output logic [DATA_W-1:0]          resData
);
  localparam int ACC_W = 2 * DATA_W;
  localparam int POS_W = $clog2(ACC_W);

  logic [DATA_W-1:0] hiBank [NUM_ACC];
  logic [DATA_W-1:0] loBank [NUM_ACC];

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiBank[i] <= '0;
        loBank[i] <= '0;
      end else if (accWrEn && accWrSel == i) begin
        hiBank[i] <= accWrHi;
        loBank[i] <= accWrLo;
      end
    end
  end

  logic [ACC_W-1:0]  accVal;
  logic [POS_W-1:0]  posCur;
  logic [POS_W-1:0]  sizeExt;
  logic [POS_W-1:0]  lsbPos;
  logic [POS_W-1:0]  nextPos;
  logic              fits;
  logic [ACC_W-1:0]  fieldMask;
  logic [ACC_W-1:0]  shifted;
  logic [DATA_W-1:0] field;
  logic [DATA_W-1:0] ctlAfter;

  always_comb begin
    accVal    = {hiBank[reqAcc], loBank[reqAcc]};
    posCur    = ctlReg[POS_W-1:0];
    sizeExt   = POS_W'(reqSize);
    fits      = posCur >= sizeExt;
    lsbPos    = posCur - sizeExt;
    nextPos   = lsbPos - POS_W'(1);
    fieldMask = (ACC_W'(1) << (32'(reqSize) + 1)) - ACC_W'(1);
    shifted   = accVal >> lsbPos;
    field     = fits ? DATA_W'(shifted & fieldMask) : '0;
    ctlAfter  = ctlReg;
    if (fits) begin
      ctlAfter[POS_W-1:0] = nextPos;
      ctlAfter[FLAG_BIT]  = 1'b0;
    end else begin
      ctlAfter[FLAG_BIT]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      resData <= '0;
    end else begin
      if (strobes.loadCtl)            ctlReg  <= ctlWrData;
      else if (strobes.applyExtract)  ctlReg  <= ctlAfter;
      if (strobes.captureResult)      resData <= field;
    end
  end
endmodule

// File: rtl/acc_extract_unit.sv
module acc_extract_unit
  import aeu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_ACC  = 4,
  parameter int SIZE_W   = 5,
  parameter int FLAG_BIT = 14,
  localparam int SEL_W   = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accWrEn,
  input  logic [SEL_W-1:0]  accWrSel,
  input  logic [DATA_W-1:0] accWrHi,
  input  logic [DATA_W-1:0] accWrLo,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  output logic [DATA_W-1:0] ctlRdData,
  input  logic              reqValid,
  input  logic [SEL_W-1:0]  reqAcc,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              resValid,
  output logic [DATA_W-1:0] resData
);
  aeuStrobes_t strobes;

  aeu_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ctlWrEn(ctlWrEn),
    .strobes(strobes), .resValid(resValid)
  );

  aeu_datapath #(
    .DATA_W(DATA_W), .NUM_ACC(NUM_ACC), .SIZE_W(SIZE_W), .FLAG_BIT(FLAG_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .accWrEn(accWrEn), .accWrSel(accWrSel), .accWrHi(accWrHi), .accWrLo(accWrLo),
    .ctlWrData(ctlWrData), .reqAcc(reqAcc), .reqSize(reqSize),
    .ctlReg(ctlRdData), .resData(resData)
  );
endmodule

// File: rtl/aeu_checker.sv
module aeu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ctlWrEn,
  input logic [31:0] ctlWrData,
  input logic [31:0] ctlRdData,
  input logic        reqValid,
  input logic [4:0]  reqSize,
  input logic        resValid,
  input logic [31:0] resData
);
  logic extOnly;
  assign extOnly = reqValid && !ctlWrEn;

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  p_success_ptr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (extOnly && ctlRdData[5:0] >= 6'(reqSize)) |=>
      (!ctlRdData[14] && ctlRdData[5:0] == $past(ctlRdData[5:0] - 6'(reqSize) - 6'd1)));
  p_fail_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (extOnly && ctlRdData[5:0] < 6'(reqSize)) |=>
      (ctlRdData[14] && resData == 32'd0 && $stable(ctlRdData[5:0])));
  p_keep_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    extOnly |=> ($stable(ctlRdData[31:15]) && $stable(ctlRdData[13:6])));
  p_ctl_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> ctlRdData == $past(ctlWrData));
  p_ctl_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlWrEn && !reqValid) |=> $stable(ctlRdData));
  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(resData));
endmodule

bind acc_extract_unit aeu_checker u_chk (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
  .ctlRdData(ctlRdData), .reqValid(reqValid), .reqSize(reqSize),
  .resValid(resValid), .resData(resData)
);

// File: tb/sim_acc_extract_unit.sv
`timescale 1ns/1ps
module sim_acc_extract_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accWrEn = 1'b0;
  logic [1:0] accWrSel = '0;
  logic [31:0] accWrHi = '0, accWrLo = '0;
  logic ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic [31:0] ctlRdData;
  logic reqValid = 1'b0;
  logic [1:0] reqAcc = '0;
  logic [4:0] reqSize = '0;
  logic resValid;
  logic [31:0] resData;

  always #2 clk = ~clk;

  acc_extract_unit u0 (
    .clk(clk), .rstN(rstN), .accWrEn(accWrEn), .accWrSel(accWrSel),
    .accWrHi(accWrHi), .accWrLo(accWrLo), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .reqValid(reqValid), .reqAcc(reqAcc), .reqSize(reqSize),
    .resValid(resValid), .resData(resData)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "R10";
  bit done = 0;

  // reference model state
  logic [31:0] mHi [4];
  logic [31:0] mLo [4];
  logic [31:0] mCtl = '0;
  logic        mValid = 1'b0;
  logic [31:0] mRes = '0;

  initial for (int i = 0; i < 4; i++) begin mHi[i] = '0; mLo[i] = '0; end

  always @(posedge clk) begin
    logic [31:0] nextCtl;
    logic [63:0] acc;
    int p, s;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mHi[i] = '0; mLo[i] = '0; end
      mCtl = '0; mValid = 1'b0; mRes = '0;
    end else begin
      nextCtl = mCtl;
      mValid = reqValid;
      if (reqValid) begin
        p = int'(mCtl[5:0]);
        s = int'(reqSize);
        if (p - (s + 1) >= -1) begin
          acc = {mHi[reqAcc], mLo[reqAcc]};
          mRes = 32'((acc >> (p - s)) & ((64'd1 << (s + 1)) - 64'd1));
          nextCtl = (mCtl & ~32'h0000_403F) | (32'(p - s - 1) & 32'h3F);
        end else begin
          mRes = 32'd0;
          nextCtl = mCtl | 32'h0000_4000;
        end
      end
      if (ctlWrEn) mCtl = ctlWrData;
      else if (reqValid) mCtl = nextCtl;
      if (accWrEn) begin mHi[accWrSel] = accWrHi; mLo[accWrSel] = accWrLo; end
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp({31'd0, resValid}, {31'd0, mValid}, "done");
    cmp(resData, mRes, "result");
    cmp(ctlRdData, mCtl, "control");
  end

  task automatic idle();
    @(negedge clk);
    accWrEn = 0; ctlWrEn = 0; reqValid = 0;
  endtask
  task automatic wrAcc(input int sel, input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    accWrEn = 1; accWrSel = 2'(sel); accWrHi = hi; accWrLo = lo; ctlWrEn = 0; reqValid = 0;
  endtask
  task automatic wrCtl(input logic [31:0] v);
    @(negedge clk);
    ctlWrEn = 1; ctlWrData = v; accWrEn = 0; reqValid = 0;
  endtask
  task automatic req(input int sel, input int size);
    @(negedge clk);
    reqValid = 1; reqAcc = 2'(sel); reqSize = 5'(size); accWrEn = 0; ctlWrEn = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R10";
    @(negedge clk); rstN = 1;
    idle();
    phase = "R6";   // pos 0 size 0 from an all-zero control register
    wrAcc(1, 32'h0, 32'h0);
    req(1, 0); idle(); idle();
    wrAcc(1, 32'h0, 32'h1); wrCtl(32'h0);
    req(1, 0); idle();
    phase = "R1";
    wrAcc(2, 32'hDEAD_BEEF, 32'h1234_5678);
    wrCtl(32'h0000_0027);            // pos 39 spans both words
    req(2, 15); idle();
    phase = "R5";                    // pointer walk with unrelated bits set
    wrCtl(32'hFFFF_BFE8);            // pos 40
    for (int k = 0; k < 7; k++) req(2, 7);
    idle();
    phase = "R4";
    wrCtl(32'h0000_0003);
    req(2, 5); idle(); req(2, 3); idle();
    phase = "R9";
    wrAcc(3, 32'hCAFE_F00D, 32'h5555_AAAA);
    wrCtl(32'h0000_003F);
    req(3, 31); idle(); req(3, 31); idle();
    phase = "R8";
    @(negedge clk);
    ctlWrEn = 1; ctlWrData = 32'h1357_9BDF; reqValid = 1; reqAcc = 3; reqSize = 2;
    accWrEn = 1; accWrSel = 3; accWrHi = 32'h0; accWrLo = 32'h0;
    idle(); req(3, 4); idle();
    phase = "R2";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      accWrEn = ($urandom_range(3) == 0); accWrSel = 2'($urandom);
      accWrHi = $urandom; accWrLo = $urandom;
      ctlWrEn = ($urandom_range(5) == 0); ctlWrData = $urandom;
      reqValid = ($urandom_range(2) != 0); reqAcc = 2'($urandom);
      reqSize = 5'($urandom_range(12));
    end
    idle(); idle();
    phase = "R3";
    wrCtl(32'h0000_0010);
    req(0, 16); idle(); req(0, 0); idle();
    finishRun();
  end
endmodule